// File: doc/BRIEF.md
# DMA Buffer Descriptor Sequencer

This block steps one DMA channel through a small table of buffer descriptors. Each descriptor holds a current address, a start address, a remaining byte count, a base byte count and an attribute word. The attribute word selects the transfer size, the direction and the action taken when the descriptor runs dry: interrupt, wrap back to the start, keep the channel running, hold the address, and which descriptor serves the next request.

Software first loads the table through a register-write port while the channel is idle, then pulses a start input. From then on, each request presented while the channel is enabled is served one cycle later. The block outputs the address, the byte count and the direction, then updates that descriptor. When a descriptor completes, the next request goes to the chained descriptor. Ping-pong pairs and cyclic rings of small descriptors for two-dimensional patterns come from the attribute bits alone. The bus master, the data FIFOs and arbitration between channels are outside this block.

Top module: `dma_desc_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ch_enabled`, `srv_valid` and `irq_pulse` are 0.
- R2: A write on `cfg_we` is stored only while the channel is disabled, and is ignored while it is enabled. `cfg_sel` picks the target field: 0 is the address (it sets both the current and the start address), 1 is the remaining count, 2 is the base count and 3 is the attribute word. The attribute word is laid out as follows: bit 0 interrupt, bit 1 wrap, bit 2 keep-running, bit 3 address hold, bit 4 read, bits 7:5 size code, and bits from 8 upward the next-descriptor index.
- R3: A `ch_start` pulse while the channel is disabled sets `ch_enabled` on the next cycle, and service begins at descriptor 0. A `ch_start` pulse while the channel is enabled has no effect.
- R4: A request (`req_valid`) in a cycle where `ch_enabled` is 1 gives `srv_valid` on the next cycle. That cycle also carries the descriptor's current address, `srv_bytes` = 2^(size code), the read bit and the descriptor index. A request while the channel is disabled produces nothing.
- R5: After a serviced request, the descriptor's address advances by `srv_bytes`, modulo 2^ADDR_W. If the hold bit is set, it stays unchanged.
- R6: After a serviced request, the remaining count drops by `srv_bytes` and saturates at zero. Reaching zero completes the descriptor.
- R7: On completion with the interrupt bit set, `irq_pulse` is 1 for that cycle together with the completing `srv_valid`, and `irq_idx` equals its `srv_idx`.
- R8: On completion with the wrap bit set, the address returns to the start address and the remaining count reloads from the base count.
- R9: On completion, the next request is served from the descriptor named by the next-descriptor index.
- R10: On completion with the keep-running bit clear, `ch_enabled` falls in the same cycle as the completing `srv_valid`. With the bit set, the channel stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor field write strobe |
| cfg_idx | input | IDX_W | Descriptor index to write |
| cfg_sel | input | 2 | Field select: 0 address, 1 remaining, 2 base, 3 attribute |
| cfg_data | input | ADDR_W | Write data (low bits used for count and attribute fields) |
| ch_start | input | 1 | Enable the channel at descriptor 0 |
| ch_enabled | output | 1 | Channel is running |
| req_valid | input | 1 | Transfer request |
| srv_valid | output | 1 | A request was serviced this cycle |
| srv_addr | output | ADDR_W | Address for the serviced transfer |
| srv_bytes | output | 8 | Byte count for the serviced transfer |
| srv_read | output | 1 | Direction: 1 read, 0 write |
| srv_idx | output | IDX_W | Descriptor that served the request |
| irq_pulse | output | 1 | One-cycle completion interrupt |
| irq_idx | output | IDX_W | Descriptor that completed |

## Verification
The bench builds the block with NUM_DESC=8, ADDR_W=16 and SIZE_W=12. The 3-bit index lets chains jump across the table: 0 goes to 2, and a four-entry ring runs back to 0. A descriptor placed at 0xFFF8 drives the address adder through its upper carry bits, and an odd remaining count of 5 with a 2-byte step reaches the zero-saturation path. A behavioural model holding integer copies of the table is compared with every output on every clock, through a hold-then-chain run that shuts down, a ping-pong pair under gapped requests with ignored writes and starts, and a cyclic 2-byte ring.

// File: rtl/dma_desc_pkg.sv
`timescale 1ns/1ps
package dma_desc_pkg;
  localparam int BYTES_W = 8;
  localparam int CODE_W  = 3;

  // attribute word bit positions (software-visible layout)
  localparam int A_IRQ  = 0;
  localparam int A_WRAP = 1;
  localparam int A_KEEP = 2;
  localparam int A_HOLD = 3;
  localparam int A_READ = 4;
  localparam int A_CODE = 5;
  localparam int A_NEXT = 8;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_SIZE = 2'd1,
    SEL_BASE = 2'd2,
    SEL_ATTR = 2'd3
  } cfg_sel_e;

  function automatic logic [BYTES_W-1:0] code_bytes(input logic [CODE_W-1:0] c);
    return BYTES_W'(1) << c;
  endfunction
endpackage

// File: rtl/dma_desc_store.sv
`timescale 1ns/1ps
module dma_desc_store #(
  parameter int NUM_DESC = 8,
  parameter int IDX_W    = 3,
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 16,
  parameter int ATTR_W   = 11
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic              we_addr,
  input  logic              we_start,
  input  logic              we_size,
  input  logic              we_base,
  input  logic              we_attr,
  input  logic [ADDR_W-1:0] w_addr,
  input  logic [SIZE_W-1:0] w_size,
  input  logic [ATTR_W-1:0] w_attr,
  input  logic [IDX_W-1:0]  r_idx,
  output logic [ADDR_W-1:0] r_addr,
  output logic [ADDR_W-1:0] r_start,
  output logic [SIZE_W-1:0] r_size,
  output logic [SIZE_W-1:0] r_base,
  output logic [ATTR_W-1:0] r_attr
);
  // one small table per field; no reset so each maps to distributed RAM
  logic [ADDR_W-1:0] addr_mem  [NUM_DESC];
  logic [ADDR_W-1:0] start_mem [NUM_DESC];
  logic [SIZE_W-1:0] size_mem  [NUM_DESC];
  logic [SIZE_W-1:0] base_mem  [NUM_DESC];
  logic [ATTR_W-1:0] attr_mem  [NUM_DESC];

  always_ff @(posedge clk) begin
    if (we_addr)  addr_mem[w_idx]  <= w_addr;
    if (we_start) start_mem[w_idx] <= w_addr;
    if (we_size)  size_mem[w_idx]  <= w_size;
    if (we_base)  base_mem[w_idx]  <= w_size;
    if (we_attr)  attr_mem[w_idx]  <= w_attr;
  end

  assign r_addr  = addr_mem[r_idx];
  assign r_start = start_mem[r_idx];
  assign r_size  = size_mem[r_idx];
  assign r_base  = base_mem[r_idx];
  assign r_attr  = attr_mem[r_idx];
endmodule

// File: rtl/dma_desc_step.sv
`timescale 1ns/1ps
module dma_desc_step
  import dma_desc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16
) (
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [SIZE_W-1:0]  cur_size,
  input  logic [SIZE_W-1:0]  base_size,
  input  logic               hold,
  input  logic               wrap,
  input  logic [CODE_W-1:0]  code,
  output logic [ADDR_W-1:0]  nxt_addr,
  output logic [SIZE_W-1:0]  nxt_size,
  output logic               done,
  output logic [BYTES_W-1:0] bytes
);
  logic [ADDR_W-1:0] step_a, adv;
  logic [SIZE_W-1:0] step_s, left;

  always_comb begin
    bytes  = code_bytes(code);
    step_a = ADDR_W'(bytes);
    step_s = SIZE_W'(bytes);
    adv    = hold ? cur_addr : cur_addr + step_a;
    left   = (cur_size > step_s) ? cur_size - step_s : '0;
    done   = (left == '0);
    nxt_addr = (done && wrap) ? start_addr : adv;
    nxt_size = (done && wrap) ? base_size  : left;
  end
endmodule

// File: rtl/dma_desc_seq.sv
`timescale 1ns/1ps
module dma_desc_seq
  import dma_desc_pkg::*;
#(
  parameter  int NUM_DESC = 8,
  parameter  int ADDR_W   = 32,
  parameter  int SIZE_W   = 16,
  localparam int IDX_W    = $clog2(NUM_DESC),
  localparam int ATTR_W   = A_NEXT + IDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [1:0]         cfg_sel,
  input  logic [ADDR_W-1:0]  cfg_data,
  input  logic               ch_start,
  output logic               ch_enabled,
  input  logic               req_valid,
  output logic               srv_valid,
  output logic [ADDR_W-1:0]  srv_addr,
  output logic [BYTES_W-1:0] srv_bytes,
  output logic               srv_read,
  output logic [IDX_W-1:0]   srv_idx,
  output logic               irq_pulse,
  output logic [IDX_W-1:0]   irq_idx
);
  logic [IDX_W-1:0]   cur_idx_q;
  logic               svc, cfg_ok;
  cfg_sel_e           sel;

  logic [IDX_W-1:0]   w_idx;
  logic               we_addr, we_start, we_size, we_base, we_attr;
  logic [ADDR_W-1:0]  w_addr;
  logic [SIZE_W-1:0]  w_size;
  logic [ATTR_W-1:0]  w_attr;

  logic [ADDR_W-1:0]  r_addr, r_start, nxt_addr;
  logic [SIZE_W-1:0]  r_size, r_base, nxt_size;
  logic [ATTR_W-1:0]  r_attr;
  logic               done;
  logic [BYTES_W-1:0] bytes;

  assign svc    = ch_enabled && req_valid;
  assign cfg_ok = cfg_we && !ch_enabled;
  assign sel    = cfg_sel_e'(cfg_sel);

  // service updates and software writes never coincide (enabled vs idle)
  always_comb begin
    w_idx    = svc ? cur_idx_q : cfg_idx;
    we_addr  = svc || (cfg_ok && sel == SEL_ADDR);
    we_start = cfg_ok && sel == SEL_ADDR;
    we_size  = svc || (cfg_ok && sel == SEL_SIZE);
    we_base  = cfg_ok && sel == SEL_BASE;
    we_attr  = cfg_ok && sel == SEL_ATTR;
    w_addr   = svc ? nxt_addr : cfg_data;
    w_size   = svc ? nxt_size : cfg_data[SIZE_W-1:0];
    w_attr   = cfg_data[ATTR_W-1:0];
  end

  dma_desc_store #(
    .NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
    .SIZE_W(SIZE_W), .ATTR_W(ATTR_W)
  ) u_store (
    .clk(clk), .w_idx(w_idx),
    .we_addr(we_addr), .we_start(we_start), .we_size(we_size),
    .we_base(we_base), .we_attr(we_attr),
    .w_addr(w_addr), .w_size(w_size), .w_attr(w_attr),
    .r_idx(cur_idx_q),
    .r_addr(r_addr), .r_start(r_start), .r_size(r_size),
    .r_base(r_base), .r_attr(r_attr)
  );

  dma_desc_step #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_step (
    .cur_addr(r_addr), .start_addr(r_start),
    .cur_size(r_size), .base_size(r_base),
    .hold(r_attr[A_HOLD]), .wrap(r_attr[A_WRAP]),
    .code(r_attr[A_CODE +: CODE_W]),
    .nxt_addr(nxt_addr), .nxt_size(nxt_size),
    .done(done), .bytes(bytes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_enabled <= 1'b0;
      cur_idx_q  <= '0;
      srv_valid  <= 1'b0;
      srv_addr   <= '0;
      srv_bytes  <= '0;
      srv_read   <= 1'b0;
      srv_idx    <= '0;
      irq_pulse  <= 1'b0;
      irq_idx    <= '0;
    end else begin
      srv_valid <= 1'b0;
      irq_pulse <= 1'b0;
      if (svc) begin
        srv_valid <= 1'b1;
        srv_addr  <= r_addr;
        srv_bytes <= bytes;
        srv_read  <= r_attr[A_READ];
        srv_idx   <= cur_idx_q;
        if (done) begin
          irq_pulse <= r_attr[A_IRQ];
          irq_idx   <= cur_idx_q;
          cur_idx_q <= r_attr[A_NEXT +: IDX_W];
          if (!r_attr[A_KEEP]) ch_enabled <= 1'b0;
        end
      end else if (!ch_enabled && ch_start) begin
        ch_enabled <= 1'b1;
        cur_idx_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/dma_desc_seq_chk.sv
`timescale 1ns/1ps
module dma_desc_seq_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ch_start,
  input logic             ch_enabled,
  input logic             req_valid,
  input logic             srv_valid,
  input logic [IDX_W-1:0] srv_idx,
  input logic             irq_pulse,
  input logic [IDX_W-1:0] irq_idx
);
  // R4
  srv_from_req_chk: assert property (@(posedge clk) disable iff (rst)
    srv_valid |-> ($past(ch_enabled) && $past(req_valid)));

  // R7
  irq_with_srv_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (srv_valid && irq_idx == srv_idx));

  // R10
  off_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ch_enabled) |-> srv_valid);

  // R3
  on_by_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ch_enabled) |-> $past(ch_start));
endmodule

bind dma_desc_seq dma_desc_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .ch_start(ch_start), .ch_enabled(ch_enabled),
  .req_valid(req_valid), .srv_valid(srv_valid), .srv_idx(srv_idx),
  .irq_pulse(irq_pulse), .irq_idx(irq_idx)
);

// File: tb/dma_desc_seq_tb.sv
`timescale 1ns/1ps
module dma_desc_seq_tb;
  localparam int ND = 8;
  localparam int AW = 16;
  localparam int SW = 12;

  logic clk = 0;
  logic rst = 1;
  logic cfg_we = 0;
  logic [2:0] cfg_idx = 0;
  logic [1:0] cfg_sel = 0;
  logic [AW-1:0] cfg_data = 0;
  logic ch_start = 0;
  logic req_valid = 0;
  logic ch_enabled, srv_valid, srv_read, irq_pulse;
  logic [AW-1:0] srv_addr;
  logic [7:0] srv_bytes;
  logic [2:0] srv_idx, irq_idx;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit armed = 0;

  always #2 clk = ~clk;

  dma_desc_seq #(.NUM_DESC(ND), .ADDR_W(AW), .SIZE_W(SW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .ch_start(ch_start),
    .ch_enabled(ch_enabled), .req_valid(req_valid), .srv_valid(srv_valid),
    .srv_addr(srv_addr), .srv_bytes(srv_bytes), .srv_read(srv_read),
    .srv_idx(srv_idx), .irq_pulse(irq_pulse), .irq_idx(irq_idx)
  );

  // ---------------- behavioural reference model ----------------
  int m_addr[ND], m_start[ND], m_size[ND], m_base[ND], m_attr[ND];
  int m_idx = 0;
  bit m_en = 0;
  bit e_sv = 0, e_irq = 0, e_rd = 0;
  int e_addr = 0, e_bytes = 0, e_sidx = 0, e_iidx = 0;

  always @(posedge clk) begin
    int i, a, b;
    bit old_en;
    armed = 1;
    if (rst) begin
      m_en = 0; m_idx = 0; e_sv = 0; e_irq = 0;
    end else begin
      old_en = m_en;
      e_sv = 0; e_irq = 0;
      if (cfg_we && !old_en) begin
        case (cfg_sel)
          2'd0: begin m_addr[cfg_idx] = int'(cfg_data); m_start[cfg_idx] = int'(cfg_data); end
          2'd1: m_size[cfg_idx] = int'(cfg_data) & 'hFFF;
          2'd2: m_base[cfg_idx] = int'(cfg_data) & 'hFFF;
          default: m_attr[cfg_idx] = int'(cfg_data) & 'h7FF;
        endcase
      end
      if (old_en && req_valid) begin
        i = m_idx; a = m_attr[i]; b = 1 << ((a >> 5) & 7);
        e_sv = 1; e_addr = m_addr[i]; e_bytes = b; e_rd = a[4]; e_sidx = i;
        if (!a[3]) m_addr[i] = (m_addr[i] + b) & 'hFFFF;
        m_size[i] = (m_size[i] > b) ? m_size[i] - b : 0;
        if (m_size[i] == 0) begin
          e_irq = a[0]; e_iidx = i;
          if (a[1]) begin m_addr[i] = m_start[i]; m_size[i] = m_base[i]; end
          m_idx = (a >> 8) & 7;
          if (!a[2]) m_en = 0;
        end
      end else if (!old_en && ch_start) begin
        m_en = 1; m_idx = 0;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R3/R10 ch_enabled", int'(ch_enabled), int'(m_en));
      chk("R4 srv_valid", int'(srv_valid), int'(e_sv));
      if (e_sv) begin
        chk("R5/R8 srv_addr", int'(srv_addr), e_addr);
        chk("R4 srv_bytes", int'(srv_bytes), e_bytes);
        chk("R4 srv_read", int'(srv_read), int'(e_rd));
        chk("R9 srv_idx", int'(srv_idx), e_sidx);
      end
      chk("R6/R7 irq_pulse", int'(irq_pulse), int'(e_irq));
      if (e_irq) chk("R7 irq_idx", int'(irq_idx), e_iidx);
    end
  end

  // ---------------- stimulus ----------------
  function automatic int mk_attr(bit irq, bit wrap, bit keep, bit hold,
                                 bit rd, int code, int nxt);
    return (nxt << 8) | (code << 5) | (rd << 4) | (hold << 3) |
           (keep << 2) | (wrap << 1) | irq;
  endfunction

  task automatic wr(int idx, int sel, int data);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_sel = 2'(sel); cfg_data = AW'(data);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic load(int idx, int addr, int size, int base, int attr);
    wr(idx, 0, addr); wr(idx, 1, size); wr(idx, 2, base); wr(idx, 3, attr);
  endtask

  task automatic pulse_start();
    ch_start = 1; @(negedge clk); ch_start = 0;
  endtask

  task automatic reqs(int n, bit gaps);
    for (int k = 0; k < n; k++) begin
      req_valid = gaps ? ((k % 3) != 1) : 1'b1;
      @(negedge clk);
    end
    req_valid = 0;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1 reset ch_enabled", int'(ch_enabled), 0);
    chk("R1 reset srv_valid", int'(srv_valid), 0);
    chk("R1 reset irq_pulse", int'(irq_pulse), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset ch_enabled", int'(ch_enabled), 0);
    for (int i = 0; i < ND; i++) load(i, 0, 0, 0, 0);

    // A: held 1-byte descriptor chains to 2, which runs near the top of
    // the address space, saturates (R6), interrupts and shuts down (R10)
    load(0, 'h0040, 3, 3, mk_attr(0, 0, 1, 1, 1, 0, 2));
    load(2, 'hFFF8, 5, 5, mk_attr(1, 0, 0, 0, 0, 1, 0));
    reqs(2, 0);                 // R4: ignored while disabled
    pulse_start();
    reqs(6, 0);
    reqs(3, 0);                 // R4: ignored after shutdown

    // B: ping-pong pair with wrap and interrupts (R8, R9, R7)
    load(0, 'h1000, 8, 8, mk_attr(1, 1, 1, 0, 1, 2, 1));
    load(1, 'h2000, 8, 8, mk_attr(1, 1, 1, 0, 0, 2, 0));
    pulse_start();
    reqs(6, 0);
    wr(1, 0, 'h3000);           // R2: ignored while enabled
    pulse_start();              // R3: ignored while enabled
    reqs(12, 1);

    // C: ring of four 2-byte cyclic descriptors; start and request together
    rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    for (int i = 0; i < 4; i++)
      load(i, 'h100 * (i + 1), 2, 2, mk_attr(i == 3, 1, 1, 0, 1, 1, (i + 1) % 4));
    ch_start = 1; req_valid = 1; @(negedge clk); ch_start = 0; req_valid = 0;
    reqs(12, 1);
    reqs(6, 0);
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule